// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This combinational unit tests a pair of IEEE-style binary floating-point operands against one of seven comparison predicates. A 3-bit select picks the predicate. The unit returns a single boolean bit and an invalid-operation flag. Some predicates are quiet and some are signaling. The unordered-flavoured predicates read a NaN on either side as a reason to answer true. The ordered ones answer false in that case.

The operand format is set by two parameters, the exponent width and the fraction width. The defaults give single precision. A narrower format can be instantiated for exhaustive checking. The caller registers the result bit wherever it needs it.

Top module: `fp_pred_cmp`

## Requirements
- R1: The operands are sign, exponent and fraction, packed from MSB to LSB. A NaN has an all-ones exponent and a nonzero fraction. A NaN with fraction MSB 1 is quiet, and with fraction MSB 0 it is signaling. Select codes: 0 UN, 1 OEQ, 2 UEQ, 3 OLT, 4 ULT, 5 OLE, 6 ULE, 7 unused.
- R2: UN (code 0) gives 1 exactly when at least one operand is NaN.
- R3: OEQ (code 1) gives 1 when both operands are non-NaN and numerically equal.
- R4: UEQ (code 2) gives 1 when the operands are numerically equal or at least one is NaN.
- R5: OLT (code 3) gives 1 when A < B, and OLE (code 5) gives 1 when A <= B. Both give 0 if either operand is NaN.
- R6: ULT (code 4) gives 1 when A < B or at least one operand is NaN.
- R7: ULE (code 6) gives 0 only when both operands are ordered and A > B.
- R8: Positive and negative zero are equal, and neither is less than the other.
- R9: For the quiet predicates (codes 0, 1, 2, 4, 6), invalid is 1 exactly when at least one operand is a signaling NaN.
- R10: For the signaling predicates (codes 3 and 5), invalid is 1 exactly when at least one operand is a NaN of either kind.
- R11: Code 7 drives result 0 and invalid 0 for every pair of operands.
- R12: Infinities take part in ordered comparison. Negative infinity is below every finite value, and positive infinity is above every finite value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 1+EXP_W+MAN_W | Left operand A |
| op_b | input | 1+EXP_W+MAN_W | Right operand B |
| pred_sel | input | 3 | Predicate select code |
| result | output | 1 | Boolean outcome of the predicate |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest cases to reach from the ports are sparse at single precision: signaling NaNs, which make up a narrow band of encodings, and mixed-sign zero pairs, which a sparse sample rarely hits. The bench therefore instantiates a 6-bit format with a 3-bit exponent and a 2-bit fraction. It sweeps every operand pair under all eight select codes, so every NaN kind, infinity, subnormal and signed-zero combination meets every predicate. A few directed single-precision vectors confirm that the default format behaves the same way.

// File: rtl/fp_pred_cmp.sv
module fp_pred_cmp #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  logic [2:0]           pred_sel,
  output logic                 result,
  output logic                 invalid
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [2:0] P_UN  = 3'd0;
  localparam logic [2:0] P_OEQ = 3'd1;
  localparam logic [2:0] P_UEQ = 3'd2;
  localparam logic [2:0] P_OLT = 3'd3;
  localparam logic [2:0] P_ULT = 3'd4;
  localparam logic [2:0] P_OLE = 3'd5;
  localparam logic [2:0] P_ULE = 3'd6;

  logic a_nan, b_nan, a_snan, b_snan, unord, any_snan;
  logic both_zero, lt, eq, gt;

  assign a_nan  = (&op_a[W-2:MAN_W]) & (|op_a[MAN_W-1:0]);
  assign b_nan  = (&op_b[W-2:MAN_W]) & (|op_b[MAN_W-1:0]);
  assign a_snan = a_nan & ~op_a[MAN_W-1];
  assign b_snan = b_nan & ~op_b[MAN_W-1];
  assign unord    = a_nan | b_nan;
  assign any_snan = a_snan | b_snan;
  assign both_zero = ~|{op_a[W-2:0], op_b[W-2:0]};

  logic lt_raw;
  always_comb begin
    if (both_zero)                 lt_raw = 1'b0;
    else if (op_a[W-1] != op_b[W-1]) lt_raw = op_a[W-1];
    else if (!op_a[W-1])           lt_raw = op_a[W-2:0] < op_b[W-2:0];
    else                           lt_raw = op_a[W-2:0] > op_b[W-2:0];
  end

  assign eq = ~unord & (both_zero | (op_a == op_b));
  assign lt = ~unord & lt_raw;
  assign gt = ~unord & ~lt_raw & ~eq;

  always_comb begin
    result  = 1'b0;
    invalid = any_snan;
    unique case (pred_sel)
      P_UN:    result = unord;
      P_OEQ:   result = eq;
      P_UEQ:   result = eq | unord;
      P_OLT:   begin result = lt;        invalid = unord; end
      P_ULT:   result = lt | unord;
      P_OLE:   begin result = lt | eq;   invalid = unord; end
      P_ULE:   result = ~gt;
      default: invalid = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_pred_cmp_chk.sv
module fp_pred_cmp_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic [2:0]           pred_sel,
  input logic                 result,
  input logic                 invalid
);
  localparam int W = 1 + EXP_W + MAN_W;
  logic na, nb, sa, sb, sig_sel;
  assign na = (op_a[W-2:MAN_W] == '1) && (op_a[MAN_W-1:0] != '0);
  assign nb = (op_b[W-2:MAN_W] == '1) && (op_b[MAN_W-1:0] != '0);
  assign sa = na && !op_a[MAN_W-1];
  assign sb = nb && !op_b[MAN_W-1];
  assign sig_sel = (pred_sel == 3'd3) || (pred_sel == 3'd5);

  always_comb begin
    if (pred_sel == 3'd0)
      a_r2_un_tracks_nan: assert (result == (na || nb));
    if (pred_sel == 3'd7)
      a_r11_unused_silent: assert (!result && !invalid);
    if ((pred_sel == 3'd1 || sig_sel) && (na || nb))
      a_r5_ordered_false_on_nan: assert (!result);
    if ((pred_sel == 3'd2 || pred_sel == 3'd4 || pred_sel == 3'd6) && (na || nb))
      a_r6_unordered_true_on_nan: assert (result);
    if (sig_sel)
      a_r10_signaling_invalid: assert (invalid == (na || nb));
    if (!sig_sel && pred_sel != 3'd7)
      a_r9_quiet_invalid: assert (invalid == (sa || sb));
    if (pred_sel == 3'd1 && op_a[W-2:0] == '0 && op_b[W-2:0] == '0)
      a_r8_zeros_equal: assert (result);
  end
endmodule

bind fp_pred_cmp fp_pred_cmp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .op_a(op_a), .op_b(op_b), .pred_sel(pred_sel), .result(result), .invalid(invalid)
);

// File: tb/tb_fp_pred_cmp.sv
module tb_fp_pred_cmp;
  localparam int EW = 3;
  localparam int MW = 2;
  localparam int W = 1 + EW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [W-1:0] a, b;
  logic [2:0] sel;
  logic res, inv;
  fp_pred_cmp #(.EXP_W(EW), .MAN_W(MW)) dut (
    .op_a(a), .op_b(b), .pred_sel(sel), .result(res), .invalid(inv));

  logic [31:0] wa, wb;
  logic [2:0] wsel;
  logic wres, winv;
  fp_pred_cmp dut_wide (
    .op_a(wa), .op_b(wb), .pred_sel(wsel), .result(wres), .invalid(winv));

  function automatic real fval(logic [W-1:0] x);
    int e = int'(x[W-2:MW]);
    real m = real'(x[MW-1:0]) / real'(1 << MW);
    real mag;
    if (e == (1 << EW) - 1) mag = 1.0e30;
    else if (e == 0) mag = m * (2.0 ** real'(1 - BIAS));
    else mag = (1.0 + m) * (2.0 ** real'(e - BIAS));
    return x[W-1] ? -mag : mag;
  endfunction

  function automatic string rtag(logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd5: return "R5";
      3'd4: return "R6";
      3'd6: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic wide(logic [31:0] x, logic [31:0] y, logic [2:0] s,
                      logic er, logic ei, string tag);
    wa = x; wb = y; wsel = s;
    #1;
    chk(tag, "wide result", wres, er);
    chk(tag, "wide invalid", winv, ei);
  endtask

  initial begin
    a = '0; b = '0; sel = 3'd0;
    wa = '0; wb = '0; wsel = 3'd0;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < (1 << W); i++) begin
        for (int j = 0; j < (1 << W); j++) begin
          logic [W-1:0] x, y;
          logic nx, ny, snx, sny, un, lt, eq, gt, er, ei;
          real fx, fy;
          x = W'(i); y = W'(j);
          nx = (x[W-2:MW] == '1) && (x[MW-1:0] != '0);
          ny = (y[W-2:MW] == '1) && (y[MW-1:0] != '0);
          snx = nx && !x[MW-1];
          sny = ny && !y[MW-1];
          fx = fval(x); fy = fval(y);
          un = nx || ny;
          lt = !un && (fx < fy);
          eq = !un && (fx == fy);
          gt = !un && (fx > fy);
          case (s)
            0: er = un;
            1: er = eq;
            2: er = eq || un;
            3: er = lt;
            4: er = lt || un;
            5: er = lt || eq;
            6: er = !gt;
            default: er = 1'b0;
          endcase
          if (s == 3 || s == 5) ei = un;        // R10
          else if (s == 7) ei = 1'b0;           // R11
          else ei = snx || sny;                 // R9
          a = x; b = y; sel = 3'(s);
          #1;
          chk(rtag(3'(s)), "result", res, er);
          chk((s == 3 || s == 5) ? "R10" : (s == 7 ? "R11" : "R9"), "invalid", inv, ei);
        end
      end
    end
    // directed single-precision vectors
    wide(32'h3F800000, 32'h40000000, 3'd3, 1'b1, 1'b0, "R1");
    wide(32'h40000000, 32'h3F800000, 3'd6, 1'b0, 1'b0, "R7");
    wide(32'h00000000, 32'h80000000, 3'd1, 1'b1, 1'b0, "R8");
    wide(32'h80000000, 32'h00000000, 3'd3, 1'b0, 1'b0, "R8");
    wide(32'h7F800000, 32'h7F7FFFFF, 3'd5, 1'b0, 1'b0, "R12");
    wide(32'hFF800000, 32'hFF7FFFFF, 3'd4, 1'b1, 1'b0, "R12");
    wide(32'h7F800001, 32'h3F800000, 3'd2, 1'b1, 1'b1, "R9");
    wide(32'h7FC00000, 32'h3F800000, 3'd6, 1'b1, 1'b0, "R9");
    wide(32'h3F800000, 32'h7FC00000, 3'd3, 1'b0, 1'b1, "R10");
    wide(32'h7F800001, 32'h7F800001, 3'd7, 1'b0, 1'b0, "R11");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule